// File: doc/BRIEF.md
# Float to Audio Sample Converter

The block turns a 32-bit IEEE-754 single-precision word into a 16-bit audio sample. It is meant for a datapath that produces normalized floating-point audio and must hand fixed-point words to a codec serializer. A one-bit mode input picks between two scalings. Signed mode multiplies by 2^15 and yields a two's-complement sample for the range -1.0 to 1.0. Unsigned mode multiplies by 2^16 and yields an offset-free code for the range 0.0 to 1.0.

Conversion truncates the fraction. Values too small to reach the lowest code flush to zero. Values whose magnitude is 1.0 or more saturate according to their sign, and this includes infinities and NaNs. The result is registered once. It appears, zero-extended to 32 bits, one clock after the input strobe. The output word keeps its value between strobes.

Top module: `f2s_sample_conv`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state has out_word = 0 and out_valid = 0.
- R2: out_valid equals in_valid one clock earlier. out_word takes the converted value in the clock after in_valid is high, and it stays unchanged after any clock in which in_valid is low, whatever in_word and in_mode do.
- R3: Bits 31:16 of out_word are always zero, and the sample sits in bits 15:0.
- R4: With in_mode = 0 (signed), an exponent field in_word[30:23] below 112 gives sample 0x0000.
- R5: With in_mode = 0, an exponent field of 127 or more (including infinities and NaNs) gives 0x7FFF when in_word[31] = 0 and 0x8000 when in_word[31] = 1.
- R6: With in_mode = 0, in_word[31] = 0 and exponent field 112..126, the sample is the 24-bit significand {1, in_word[22:0]} logically shifted right by (135 - exponent), truncated, and limited to at most 0x7FFF.
- R7: With in_mode = 0, in_word[31] = 1 and exponent field 112..126, the sample is the 16-bit two's complement of the shifted magnitude from R6, with any carry out of bit 15 dropped.
- R8: With in_mode = 1 (unsigned), any word with in_word[31] = 1 gives 0x0000.
- R9: With in_mode = 1 and in_word[31] = 0, an exponent field below 111 gives 0x0000, and one of 127 or more gives 0xFFFF.
- R10: With in_mode = 1, in_word[31] = 0 and exponent field 111..126, the sample is the 24-bit significand shifted right by (134 - exponent), truncated, and limited to at most 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: in_word and in_mode are to be converted |
| in_word | input | 32 | Single-precision floating-point value |
| in_mode | input | 1 | 0 = signed scaling by 2^15, 1 = unsigned scaling by 2^16 |
| out_valid | output | 1 | Strobe: out_word carries a new sample |
| out_word | output | 32 | Zero-extended 16-bit sample |

## Verification
The bound assertions take for granted that in_word and in_mode carry known values whenever in_valid is high, and that in_valid is low throughout reset. Under those conditions, an assertion that compares a result with the previous cycle's inputs never sees a strobe that arrived during reset. The bench drives every input on the falling edge. It holds in_valid low for the whole reset period. Between strobes it scrambles in_word and in_mode, so the hold property is tested against inputs that change while they should be ignored.

// File: rtl/f2s_pkg.sv
// Package f2s_pkg
// Shared constants and types for the float-to-sample converter.
// Assumes the IEEE-754 single-precision layout: sign, 8-bit exponent, 23-bit fraction.
package f2s_pkg;

    localparam int FLT_W      = 32;
    localparam int FLT_EXP_W  = 8;
    localparam int FLT_FRAC_W = 23;

    // Scaling selector carried on the in_mode pin
    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } f2s_mode_e;

    // Decoded floating-point fields; sig holds the hidden one at its top bit
    typedef struct packed {
        logic                  sign;
        logic [FLT_EXP_W-1:0]  exp;
        logic [FLT_FRAC_W:0]   sig;
    } f2s_fields_t;

endpackage

// File: rtl/f2s_unpack.sv
// Module f2s_unpack
// Splits a single-precision word into sign, biased exponent and a 24-bit
// significand with the implicit leading one forced on.
// Assumes normal numbers; denormals are treated like normals, but they land
// below every flush threshold, so they never reach the output.
module f2s_unpack
    import f2s_pkg::*;
(
    input  logic [FLT_W-1:0] word_i,
    output f2s_fields_t      fields_o
);

    localparam int EXP_LSB = FLT_FRAC_W;
    localparam int EXP_MSB = FLT_FRAC_W + FLT_EXP_W - 1;

    // Field extraction
    always_comb begin
        fields_o.sign = word_i[FLT_W-1];
        fields_o.exp  = word_i[EXP_MSB:EXP_LSB];
        fields_o.sig  = {1'b1, word_i[FLT_FRAC_W-1:0]};
    end

endmodule

// File: rtl/f2s_lane.sv
// Module f2s_lane
// One scaling path. IS_SIGNED picks the variant:
//   signed   - scale by 2^(SAMPLE_W-1), saturate by sign, negate in two's complement
//   unsigned - scale by 2^SAMPLE_W, force negatives to zero, saturate to all ones
// Assumes SAMPLE_W <= FLT_FRAC_W + 1, so that every in-range shift is non-negative.
module f2s_lane
    import f2s_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter bit IS_SIGNED = 1'b1
) (
    input  f2s_fields_t          fields_i,
    output logic [SAMPLE_W-1:0]  sample_o
);

    localparam int BIAS       = (1 << (FLT_EXP_W - 1)) - 1;
    localparam int MAG_BITS   = IS_SIGNED ? SAMPLE_W - 1 : SAMPLE_W;
    localparam int LOW_EXP    = BIAS - MAG_BITS;
    localparam int SHIFT_BASE = BIAS + FLT_FRAC_W - MAG_BITS;
    localparam int SIG_W      = FLT_FRAC_W + 1;

    localparam logic [FLT_EXP_W-1:0] LOW_E   = FLT_EXP_W'(LOW_EXP);
    localparam logic [FLT_EXP_W-1:0] TOP_E   = FLT_EXP_W'(BIAS);
    localparam logic [FLT_EXP_W-1:0] SHIFT_E = FLT_EXP_W'(SHIFT_BASE);
    localparam logic [SIG_W-1:0]     CLIP_V  = SIG_W'((1 << MAG_BITS) - 1);

    logic [FLT_EXP_W-1:0] shamt;
    logic [SIG_W-1:0]     mag_full;
    logic [SAMPLE_W-1:0]  mag_clip;
    logic                 under_rng;
    logic                 over_rng;

    // Right-shift amount, truncated magnitude and its ceiling clip
    always_comb begin
        shamt     = SHIFT_E - fields_i.exp;
        mag_full  = fields_i.sig >> shamt;
        mag_clip  = (mag_full > CLIP_V) ? CLIP_V[SAMPLE_W-1:0] : mag_full[SAMPLE_W-1:0];
        under_rng = fields_i.exp < LOW_E;
        over_rng  = fields_i.exp >= TOP_E;
    end

    generate
        if (IS_SIGNED) begin : g_signed
            localparam logic [SAMPLE_W-1:0] SAT_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
            localparam logic [SAMPLE_W-1:0] SAT_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

            logic [SAMPLE_W-1:0] mag_neg;

            // Two's complement of the low bits; the carry out is dropped
            always_comb mag_neg = (~mag_full[SAMPLE_W-1:0]) + SAMPLE_W'(1);

            // Range selection for the signed mapping
            always_comb begin
                if (under_rng)
                    sample_o = '0;
                else if (over_rng)
                    sample_o = fields_i.sign ? SAT_NEG : SAT_POS;
                else if (fields_i.sign)
                    sample_o = mag_neg;
                else
                    sample_o = mag_clip;
            end
        end else begin : g_unsigned
            // Range selection for the unsigned mapping; the sign test wins
            always_comb begin
                if (fields_i.sign)
                    sample_o = '0;
                else if (under_rng)
                    sample_o = '0;
                else if (over_rng)
                    sample_o = '1;
                else
                    sample_o = mag_clip;
            end
        end
    endgenerate

endmodule

// File: rtl/f2s_sample_conv.sv
// Module f2s_sample_conv
// Top level: decodes the float, runs both scaling lanes side by side, picks one
// by in_mode and registers it. The result and its strobe appear one clock after
// in_valid. The sample register holds between strobes.
// Assumes in_word and in_mode are known whenever in_valid is high.
module f2s_sample_conv
    import f2s_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int OUT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FLT_W-1:0] in_word,
    input  logic             in_mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);

    localparam int PAD_W   = OUT_W - SAMPLE_W;
    localparam int N_LANES = 2;

    f2s_fields_t         fields;
    logic [SAMPLE_W-1:0] lane_out [N_LANES];
    logic [SAMPLE_W-1:0] lane_sel;
    logic [SAMPLE_W-1:0] sample_q;
    logic                valid_q;

    f2s_unpack u_unpack (
        .word_i   (in_word),
        .fields_o (fields)
    );

    // Lane 0 follows MODE_SIGNED, lane 1 follows MODE_UNSIGNED
    generate
        for (genvar m = 0; m < N_LANES; m++) begin : g_lane
            f2s_lane #(
                .SAMPLE_W  (SAMPLE_W),
                .IS_SIGNED (m == 0)
            ) u_lane (
                .fields_i (fields),
                .sample_o (lane_out[m])
            );
        end
    endgenerate

    // Mode multiplexer
    always_comb lane_sel = (f2s_mode_e'(in_mode) == MODE_UNSIGNED) ? lane_out[1] : lane_out[0];

    // Output register: capture on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                sample_q <= lane_sel;
        end
    end

    // Zero extension onto the wide output word
    always_comb begin
        out_word  = {{PAD_W{1'b0}}, sample_q};
        out_valid = valid_q;
    end

endmodule

// File: rtl/f2s_sample_conv_chk.sv
// Module f2s_sample_conv_chk
// Property checker bound to f2s_sample_conv. It sees only ports plus the sign
// and exponent slices of the input word.
module f2s_sample_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_mode,
    input logic        in_sign,
    input logic [7:0]  in_exp,
    input logic        out_valid,
    input logic [31:0] out_word
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_word == 32'h0 && !out_valid));

    assert_valid_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_word[31:16] == 16'h0);

    assert_signed_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_exp < 8'd112) |=> out_word == 32'h0);

    assert_signed_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_exp >= 8'd127) |=>
        out_word == ($past(in_sign) ? 32'h8000 : 32'h7FFF));

    assert_unsigned_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && in_sign) |=> out_word == 32'h0);

    assert_unsigned_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && !in_sign && in_exp >= 8'd127) |=> out_word == 32'h0000FFFF);

endmodule

bind f2s_sample_conv f2s_sample_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_sign   (in_word[31]),
    .in_exp    (in_word[30:23]),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/tb_f2s_sample_conv.sv
`timescale 1ns/1ps
module tb_f2s_sample_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = 32'h0;
    logic        in_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    f2s_sample_conv dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // Arithmetic reference built from the requirements
    function automatic logic [15:0] ref_model(logic [31:0] w, logic uns);
        int     e   = int'(w[30:23]);
        bit     s   = w[31];
        longint sig = longint'({1'b1, w[22:0]});
        longint mag;
        if (!uns) begin
            if (e < 112) return 16'h0;
            if (e >= 127) return s ? 16'h8000 : 16'h7FFF;
            mag = sig / (longint'(1) << (135 - e));
            if (!s) return (mag > 32767) ? 16'h7FFF : 16'(mag);
            return 16'((65536 - mag) % 65536);
        end
        if (s) return 16'h0;
        if (e < 111) return 16'h0;
        if (e >= 127) return 16'hFFFF;
        mag = sig / (longint'(1) << (134 - e));
        return (mag > 65535) ? 16'hFFFF : 16'(mag);
    endfunction

    function automatic string tag_of(logic [31:0] w, logic uns);
        int e = int'(w[30:23]);
        if (uns) begin
            if (w[31]) return "R8";
            if (e < 111 || e >= 127) return "R9";
            return "R10";
        end
        if (e < 112) return "R4";
        if (e >= 127) return "R5";
        if (w[31]) return "R7";
        return "R6";
    endfunction

    task automatic check_word(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // Drive one strobe, then compare the registered result one clock later
    task automatic apply(logic [31:0] w, logic uns, logic [15:0] expv, string tag);
        in_word  = w;
        in_mode  = uns;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = ~w;
        in_mode  = ~uns;
        check_word(tag, out_word, {16'h0, expv});
        check_word("R2", {31'h0, out_valid}, 32'h1);
        check_word("R3", {16'h0, out_word[31:16]}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'h1D2C3B4A;
        repeat (3) @(negedge clk);
        check_word("R1", {31'h0, out_valid}, 32'h0);
        check_word("R1", out_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_word("R2", {31'h0, out_valid}, 32'h0);

        // Directed corner values
        apply(32'h00000000, 1'b0, 16'h0000, "R4");
        apply(32'h3F800000, 1'b0, 16'h7FFF, "R5");
        apply(32'hBF800000, 1'b0, 16'h8000, "R5");
        apply(32'h3F000000, 1'b0, 16'h4000, "R6");
        apply(32'hBF000000, 1'b0, 16'hC000, "R7");
        apply(32'h3F7FFFFF, 1'b0, 16'h7FFF, "R6");
        apply(32'hBF7FFFFF, 1'b0, 16'h8001, "R7");
        apply(32'h38000000, 1'b0, 16'h0001, "R6");
        apply(32'hB8000000, 1'b0, 16'hFFFF, "R7");
        apply(32'h37800000, 1'b0, 16'h0000, "R4");
        apply(32'h7F800000, 1'b0, 16'h7FFF, "R5");
        apply(32'hFF800000, 1'b0, 16'h8000, "R5");
        apply(32'hFFC00000, 1'b0, 16'h8000, "R5");
        apply(32'h3F800000, 1'b1, 16'hFFFF, "R9");
        apply(32'h3F000000, 1'b1, 16'h8000, "R10");
        apply(32'h3F7FFFFF, 1'b1, 16'hFFFF, "R10");
        apply(32'h38000000, 1'b1, 16'h0002, "R10");
        apply(32'h37800000, 1'b1, 16'h0001, "R10");
        apply(32'h37000000, 1'b1, 16'h0000, "R9");
        apply(32'h7FC00000, 1'b1, 16'hFFFF, "R9");
        apply(32'hBF000000, 1'b1, 16'h0000, "R8");
        apply(32'hFF800000, 1'b1, 16'h0000, "R8");

        // Hold between strobes while the inputs wander
        apply(32'h3E800000, 1'b0, 16'h2000, "R6");
        for (int k = 0; k < 3; k++) begin
            in_word = 32'h3F800000 ^ 32'(k);
            in_mode = k[0];
            @(negedge clk);
            check_word("R2", out_word, 32'h00002000);
            check_word("R2", {31'h0, out_valid}, 32'h0);
        end

        // Sweep: every exponent, both signs, both modes, several fractions
        for (int e = 0; e < 256; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int f = 0; f < 6; f++) begin
                        logic [22:0] frac;
                        logic [31:0] w;
                        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                        case (f)
                            0: frac = 23'h000000;
                            1: frac = 23'h7FFFFF;
                            2: frac = 23'h400000;
                            3: frac = 23'h2AAAAA;
                            4: frac = 23'h000001;
                            default: frac = lfsr[22:0];
                        endcase
                        w = {s[0], e[7:0], frac};
                        apply(w, m[0], ref_model(w, m[0]), tag_of(w, m[0]));
                    end
                end
            end
        end

        // Reset in mid-run clears the held sample
        apply(32'h3F000000, 1'b1, 16'h8000, "R10");
        rst_n = 1'b0;
        @(negedge clk);
        check_word("R1", out_word, 32'h0);
        check_word("R1", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule